// File: doc/BRIEF.md
# Two-Master Phased Memory Arbiter

This block sits between two bus masters, a main CPU and a coprocessor, and three shared targets: an on-chip RAM, a flash region and a peripheral register block. It runs on a clock at twice the bus rate. An internal slot flag splits every bus cycle into a high slot and a low slot. The RAM is shared by time slot. The CPU may use only the high slot. The coprocessor always holds the low slot, and it also takes the high slot whenever the CPU does not want the RAM. This gives the coprocessor up to twice the RAM bandwidth of the CPU.

Flash and register accesses take a fixed number of clock cycles, set by a parameter for each region. A fixed-priority port for each region starts the CPU first when both masters arrive together. It never breaks into an access that is already under way, so a colliding coprocessor access waits until the CPU access has finished. The two slow regions are arbitrated apart from each other.

Each master has a request, write enable, address, write data, read data and ready. Ready is combinational: it is high in the clock cycle in which the access is carried out. The target ports have combinational read data and are written at the clock edge that ends a cycle in which both enable and write enable are high. A stalled master keeps its request, address and data steady until it sees ready.

Top module: `pma_arbiter`

## Requirements
- R1: The region comes from address bits [15:14]: 00 selects the RAM, 01 selects the flash, and 10 or 11 selects the register block.
- R2: The slot flag `bus_phase_hi` is 1 in the first clock cycle with `rst_n` high after reset and alternates on every clock cycle from then on (1 = high slot, 0 = low slot).
- R3: A CPU RAM access is carried out and acknowledged only in a high slot. A CPU RAM request that is raised in a low slot gets ready in the following high slot.
- R4: A coprocessor RAM request present in a low slot is carried out and acknowledged in that slot, even when the CPU is using every high slot.
- R5: In a high slot with no CPU RAM request, a coprocessor RAM request is served. A coprocessor that requests the RAM continuously while the CPU is idle gets ready in every clock cycle.
- R6: When both masters write the same RAM address in one bus cycle, the high-slot (CPU) write lands first and the low-slot (coprocessor) write lands second, so the coprocessor value is the one that stays.
- R7: A flash access takes FLASH_LAT clock cycles and a register access takes REG_LAT clock cycles. Ready, and read data taken from the target, come on the last of those cycles.
- R8: When both masters request the same idle slow region in the same cycle, the CPU is served first. The coprocessor gets ready exactly one access length after the CPU.
- R9: An access to a slow region that has started is never interrupted. A CPU request that arrives while a coprocessor access is in progress waits until that access completes.
- R10: Flash and register-block accesses are arbitrated on their own, so one master on the flash and the other on the register block both finish in their own latency.
- R11: After reset with no requests, both ready outputs and all three target enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU write enable |
| cpu_addr | input | AW | CPU address |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data, valid when ready |
| cpu_rdy | output | 1 | CPU access carried out this cycle |
| cop_req | input | 1 | Coprocessor access request |
| cop_we | input | 1 | Coprocessor write enable |
| cop_addr | input | AW | Coprocessor address |
| cop_wdata | input | DW | Coprocessor write data |
| cop_rdata | output | DW | Coprocessor read data, valid when ready |
| cop_rdy | output | 1 | Coprocessor access carried out this cycle |
| bus_phase_hi | output | 1 | Slot flag, 1 = high slot |
| ram_en | output | 1 | RAM enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data |
| fl_en | output | 1 | Flash enable |
| fl_we | output | 1 | Flash write enable |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data |
| rg_en | output | 1 | Register block enable |
| rg_we | output | 1 | Register block write enable |
| rg_addr | output | AW | Register block address |
| rg_wdata | output | DW | Register block write data |
| rg_rdata | input | DW | Register block read data |

## Verification
The bench lines requests up with a chosen slot. A design that let the CPU into a low slot would show ready one cycle early. A design that gave the high slot away while the CPU wants the RAM would lose the CPU's write in the same-address test, or would leave the coprocessor stuck for a whole bus cycle. On the slow regions it makes the two masters collide head-on and also one cycle apart. A design without CPU priority would swap the ready cycles, and one that preempts would cut the coprocessor access short. It also runs a CPU flash access alongside a coprocessor register access. A single shared arbiter would delay one of them by a full access length.

// File: rtl/pma_pkg.sv
// Package: shared types and the address decode used by the arbiter.
// Assumes the region is selected by the two most significant address bits.
package pma_pkg;

    typedef enum logic [1:0] {
        RGN_RAM   = 2'd0,
        RGN_FLASH = 2'd1,
        RGN_REG   = 2'd2
    } region_e;

    typedef enum logic {
        OWN_CPU = 1'b0,
        OWN_COP = 1'b1
    } owner_e;

    // Maps the two top address bits to a target region.
    function automatic region_e decode_region(input logic [1:0] top_bits);
        region_e r;
        case (top_bits)
            2'b00:   r = RGN_RAM;
            2'b01:   r = RGN_FLASH;
            default: r = RGN_REG;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pma_phase_gen.sv
// Slot flag generator: marks the high and low halves of each bus cycle.
// Assumes clk runs at twice the bus rate. After reset, the first cycle is a high slot.
module pma_phase_gen (
    input  logic clk,
    input  logic rst_n,
    output logic phase_hi
);

    logic phase_q;

    // Toggles the slot flag every clock and resets it to the high slot.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b1;
        else        phase_q <= ~phase_q;
    end

    assign phase_hi = phase_q;

    AST_PHASE_HI_TO_LO: assert property (@(posedge clk) disable iff (!rst_n)
        phase_hi |=> !phase_hi); // R2
    AST_PHASE_LO_TO_HI: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_hi |=> phase_hi); // R2

endmodule

// File: rtl/pma_ram_slot.sv
// RAM slot arbiter: the CPU may use only the high slot, the coprocessor owns
// the low slot and takes the high slot whenever the CPU leaves it free.
// Assumes a single-cycle RAM with combinational read data.
module pma_ram_slot #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phase_hi,
    input  logic          cpu_want,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cop_want,
    input  logic          cop_we,
    input  logic [AW-1:0] cop_addr,
    input  logic [DW-1:0] cop_wdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          cpu_done,
    output logic          cop_done
);

    logic gnt_cpu;
    logic gnt_cop;

    // Chooses the slot owner: CPU in a high slot, otherwise the coprocessor.
    always_comb begin
        gnt_cpu = phase_hi & cpu_want;
        gnt_cop = cop_want & ~gnt_cpu;
    end

    // Steers the granted master's access onto the RAM port.
    always_comb begin
        mem_en    = gnt_cpu | gnt_cop;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (gnt_cpu) begin
            mem_we    = cpu_we;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
        end else if (gnt_cop) begin
            mem_we    = cop_we;
            mem_addr  = cop_addr;
            mem_wdata = cop_wdata;
        end
    end

    assign cpu_done = gnt_cpu;
    assign cop_done = gnt_cop;

    AST_RAM_CPU_HIGH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> phase_hi); // R3
    AST_RAM_COP_LOW_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_hi && cop_want) |-> cop_done); // R4
    AST_RAM_COP_SPARE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_hi && cop_done) |-> !cpu_want); // R5
    AST_RAM_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_done && cop_done)); // R6

endmodule

// File: rtl/pma_prio_port.sv
// Fixed-priority port for one slow region (flash or register block).
// An access lasts LAT cycles and is never preempted. When the port is idle,
// a CPU request wins over a coprocessor request.
// Assumes each master holds its request and fields steady until it is done.
module pma_prio_port #(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_want,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cop_want,
    input  logic          cop_we,
    input  logic [AW-1:0] cop_addr,
    input  logic [DW-1:0] cop_wdata,
    output logic          tgt_en,
    output logic          tgt_we,
    output logic [AW-1:0] tgt_addr,
    output logic [DW-1:0] tgt_wdata,
    output logic          cpu_done,
    output logic          cop_done
);
    import pma_pkg::*;

    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] LAST = CW'(LAT - 1);

    logic          busy_q;
    owner_e        owner_q;
    logic [CW-1:0] cnt_q;
    owner_e        cur_owner;
    logic          active;
    logic [CW-1:0] cur_cnt;
    logic          done;

    // Works out the owner and the progress of the access in this cycle.
    always_comb begin
        if (busy_q)        cur_owner = owner_q;
        else if (cpu_want) cur_owner = OWN_CPU;
        else               cur_owner = OWN_COP;
        active  = busy_q | cpu_want | cop_want;
        cur_cnt = busy_q ? cnt_q : '0;
        done    = active && (cur_cnt == LAST);
    end

    // Drives the target port from the current owner.
    always_comb begin
        tgt_en    = active;
        tgt_we    = 1'b0;
        tgt_addr  = '0;
        tgt_wdata = '0;
        if (active) begin
            if (cur_owner == OWN_CPU) begin
                tgt_we    = cpu_we;
                tgt_addr  = cpu_addr;
                tgt_wdata = cpu_wdata;
            end else begin
                tgt_we    = cop_we;
                tgt_addr  = cop_addr;
                tgt_wdata = cop_wdata;
            end
        end
    end

    assign cpu_done = done && (cur_owner == OWN_CPU);
    assign cop_done = done && (cur_owner == OWN_COP);

    // Keeps the owner locked and counts cycles until the access completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            owner_q <= OWN_CPU;
            cnt_q   <= '0;
        end else if (active && !done) begin
            busy_q  <= 1'b1;
            owner_q <= cur_owner;
            cnt_q   <= cur_cnt + 1'b1;
        end else begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
        end
    end

    AST_SLOW_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_done && cop_done)); // R8
    AST_SLOW_CPU_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && cpu_want && cop_want) |-> !cop_done); // R8
    AST_SLOW_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !done && cur_owner == OWN_COP) |=> !cpu_done); // R9
    AST_SLOW_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && (cpu_want || cop_want) && LAT > 1) |-> !(cpu_done || cop_done)); // R7

endmodule

// File: rtl/pma_arbiter.sv
// Top of the two-master phased memory arbiter. It decodes each master's
// region, steers RAM requests into the slot arbiter and flash/register requests
// into their own fixed-priority ports, then routes ready and read data back.
// Assumes clk at twice the bus rate and masters that hold requests until ready.
module pma_arbiter #(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int FLASH_LAT = 3,
    parameter int REG_LAT   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_rdy,
    input  logic          cop_req,
    input  logic          cop_we,
    input  logic [AW-1:0] cop_addr,
    input  logic [DW-1:0] cop_wdata,
    output logic [DW-1:0] cop_rdata,
    output logic          cop_rdy,
    output logic          bus_phase_hi,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata,
    output logic          fl_en,
    output logic          fl_we,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic [DW-1:0] fl_rdata,
    output logic          rg_en,
    output logic          rg_we,
    output logic [AW-1:0] rg_addr,
    output logic [DW-1:0] rg_wdata,
    input  logic [DW-1:0] rg_rdata
);
    import pma_pkg::*;

    localparam int NSLOW = 2;

    region_e cpu_rgn;
    region_e cop_rgn;
    logic    phase_hi;
    logic    ram_cpu_done;
    logic    ram_cop_done;

    logic [NSLOW-1:0] slow_cpu_done;
    logic [NSLOW-1:0] slow_cop_done;
    logic [NSLOW-1:0] slow_en;
    logic [NSLOW-1:0] slow_we;
    logic [AW-1:0]    slow_addr  [NSLOW];
    logic [DW-1:0]    slow_wdata [NSLOW];

    // Decodes the target region of each master.
    always_comb begin
        cpu_rgn = decode_region(cpu_addr[AW-1:AW-2]);
        cop_rgn = decode_region(cop_addr[AW-1:AW-2]);
    end

    pma_phase_gen u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_hi (phase_hi)
    );

    assign bus_phase_hi = phase_hi;

    pma_ram_slot #(.AW(AW), .DW(DW)) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_hi  (phase_hi),
        .cpu_want  (cpu_req && cpu_rgn == RGN_RAM),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cop_want  (cop_req && cop_rgn == RGN_RAM),
        .cop_we    (cop_we),
        .cop_addr  (cop_addr),
        .cop_wdata (cop_wdata),
        .mem_en    (ram_en),
        .mem_we    (ram_we),
        .mem_addr  (ram_addr),
        .mem_wdata (ram_wdata),
        .cpu_done  (ram_cpu_done),
        .cop_done  (ram_cop_done)
    );

    // One independent priority port per slow region: index 0 flash, 1 registers.
    for (genvar g = 0; g < NSLOW; g++) begin : g_slow
        localparam int      LAT = (g == 0) ? FLASH_LAT : REG_LAT;
        localparam region_e RGN = (g == 0) ? RGN_FLASH : RGN_REG;

        pma_prio_port #(.AW(AW), .DW(DW), .LAT(LAT)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .cpu_want  (cpu_req && cpu_rgn == RGN),
            .cpu_we    (cpu_we),
            .cpu_addr  (cpu_addr),
            .cpu_wdata (cpu_wdata),
            .cop_want  (cop_req && cop_rgn == RGN),
            .cop_we    (cop_we),
            .cop_addr  (cop_addr),
            .cop_wdata (cop_wdata),
            .tgt_en    (slow_en[g]),
            .tgt_we    (slow_we[g]),
            .tgt_addr  (slow_addr[g]),
            .tgt_wdata (slow_wdata[g]),
            .cpu_done  (slow_cpu_done[g]),
            .cop_done  (slow_cop_done[g])
        );
    end

    assign fl_en    = slow_en[0];
    assign fl_we    = slow_we[0];
    assign fl_addr  = slow_addr[0];
    assign fl_wdata = slow_wdata[0];
    assign rg_en    = slow_en[1];
    assign rg_we    = slow_we[1];
    assign rg_addr  = slow_addr[1];
    assign rg_wdata = slow_wdata[1];

    // Routes ready and read data back to the CPU from its region.
    always_comb begin
        case (cpu_rgn)
            RGN_RAM:   begin cpu_rdy = ram_cpu_done;     cpu_rdata = ram_rdata; end
            RGN_FLASH: begin cpu_rdy = slow_cpu_done[0]; cpu_rdata = fl_rdata;  end
            default:   begin cpu_rdy = slow_cpu_done[1]; cpu_rdata = rg_rdata;  end
        endcase
    end

    // Routes ready and read data back to the coprocessor from its region.
    always_comb begin
        case (cop_rgn)
            RGN_RAM:   begin cop_rdy = ram_cop_done;     cop_rdata = ram_rdata; end
            RGN_FLASH: begin cop_rdy = slow_cop_done[0]; cop_rdata = fl_rdata;  end
            default:   begin cop_rdy = slow_cop_done[1]; cop_rdata = rg_rdata;  end
        endcase
    end

    AST_CPU_RDY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |-> cpu_req); // R7
    AST_COP_RDY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cop_rdy |-> cop_req); // R7
    AST_CPU_RAM_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rdy && cpu_rgn == RGN_RAM) |-> bus_phase_hi); // R3
    AST_COP_RAM_LOW_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_req && cop_rgn == RGN_RAM && !bus_phase_hi) |-> cop_rdy); // R4
    AST_REGIONS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cop_req && cpu_rgn != cop_rgn && cpu_rgn != RGN_RAM
         && cop_rgn != RGN_RAM) |-> (fl_en && rg_en)); // R10

endmodule

// File: tb/pma_arbiter_tb.sv
// Directed bench for the phased arbiter: one task per scenario, each checking itself.
module pma_arbiter_tb_top;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int FL = 3;
    localparam int RG = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_rdy;
    logic          cop_req = 1'b0, cop_we = 1'b0;
    logic [AW-1:0] cop_addr = '0;
    logic [DW-1:0] cop_wdata = '0;
    logic [DW-1:0] cop_rdata;
    logic          cop_rdy;
    logic          bus_phase_hi;
    logic          ram_en, ram_we, fl_en, fl_we, rg_en, rg_we;
    logic [AW-1:0] ram_addr, fl_addr, rg_addr;
    logic [DW-1:0] ram_wdata, fl_wdata, rg_wdata;
    logic [DW-1:0] ram_rdata, fl_rdata, rg_rdata;

    logic [DW-1:0] ram_m [64];
    logic [DW-1:0] fl_m  [64];
    logic [DW-1:0] rg_m  [64];

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    pma_arbiter #(.AW(AW), .DW(DW), .FLASH_LAT(FL), .REG_LAT(RG)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_rdy(cpu_rdy),
        .cop_req(cop_req), .cop_we(cop_we), .cop_addr(cop_addr), .cop_wdata(cop_wdata),
        .cop_rdata(cop_rdata), .cop_rdy(cop_rdy),
        .bus_phase_hi(bus_phase_hi),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata),
        .fl_en(fl_en), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata),
        .rg_en(rg_en), .rg_we(rg_we), .rg_addr(rg_addr), .rg_wdata(rg_wdata),
        .rg_rdata(rg_rdata)
    );

    assign ram_rdata = ram_m[ram_addr[5:0]];
    assign fl_rdata  = fl_m[fl_addr[5:0]];
    assign rg_rdata  = rg_m[rg_addr[5:0]];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (ram_en && ram_we) ram_m[ram_addr[5:0]] <= ram_wdata;
        if (fl_en && fl_we)   fl_m[fl_addr[5:0]]   <= fl_wdata;
        if (rg_en && rg_we)   rg_m[rg_addr[5:0]]   <= rg_wdata;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Waits until the cycle just started has the wanted slot flag.
    task automatic align(input logic want);
        @(posedge clk); #1;
        while (bus_phase_hi != want) begin
            @(posedge clk); #1;
        end
    endtask

    // Runs one access per master. Each master raises its request after its
    // delay and holds it until ready. Ready cycles are counted from the start.
    task automatic run_pair(
        input logic cpu_on, input int cpu_dly, input logic cwe,
        input logic [AW-1:0] ca, input logic [DW-1:0] cd,
        input logic cop_on, input int cop_dly, input logic pwe,
        input logic [AW-1:0] pa, input logic [DW-1:0] pd,
        output int cpu_cyc, output logic [DW-1:0] cpu_rd,
        output int cop_cyc, output logic [DW-1:0] cop_rd);
        logic cdone, pdone;
        cdone = !cpu_on; pdone = !cop_on;
        cpu_cyc = -1; cop_cyc = -1; cpu_rd = '0; cop_rd = '0;
        for (int i = 0; i < 40 && !(cdone && pdone); i++) begin
            if (cpu_on && i == cpu_dly) begin
                cpu_req = 1'b1; cpu_we = cwe; cpu_addr = ca; cpu_wdata = cd;
            end
            if (cop_on && i == cop_dly) begin
                cop_req = 1'b1; cop_we = pwe; cop_addr = pa; cop_wdata = pd;
            end
            @(negedge clk); #1;
            if (!cdone && cpu_req && cpu_rdy) begin
                cdone = 1'b1; cpu_cyc = i; cpu_rd = cpu_rdata;
            end
            if (!pdone && cop_req && cop_rdy) begin
                pdone = 1'b1; cop_cyc = i; cop_rd = cop_rdata;
            end
            @(posedge clk); #1;
            if (cdone) begin cpu_req = 1'b0; cpu_we = 1'b0; end
            if (pdone) begin cop_req = 1'b0; cop_we = 1'b0; end
        end
        cpu_req = 1'b0; cop_req = 1'b0; cpu_we = 1'b0; cop_we = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        check("R2 first slot after reset is high", bus_phase_hi, 1);
        check("R11 cpu_rdy low after reset", cpu_rdy, 0);
        check("R11 cop_rdy low after reset", cop_rdy, 0);
        check("R11 no target enabled after reset", {ram_en, fl_en, rg_en}, 0);
        @(negedge clk); #1;
        check("R2 second slot is low", bus_phase_hi, 0);
        @(negedge clk); #1;
        check("R2 third slot is high", bus_phase_hi, 1);
    endtask

    task automatic t_cpu_ram_slot();
        int cc, pc; logic [DW-1:0] cr, pr;
        align(1'b0);
        run_pair(1, 0, 1, 16'h0003, 16'h5A5A, 0, 0, 0, '0, '0, cc, cr, pc, pr);
        check("R3 cpu ram write raised in low slot waits one cycle", cc, 1);
        align(1'b1);
        run_pair(1, 0, 0, 16'h0003, '0, 0, 0, 0, '0, '0, cc, cr, pc, pr);
        check("R3 cpu ram read in high slot ready at once", cc, 0);
        check("R3 cpu ram read data", cr, 16'h5A5A);
    endtask

    task automatic t_cop_alone();
        int hits;
        align(1'b1);
        cop_req = 1'b1; cop_we = 1'b0; cop_addr = 16'h0007;
        hits = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #1;
            if (cop_rdy) hits++;
            if (cop_rdy && cop_rdata != 16'hA007) hits = hits - 100;
            @(posedge clk); #1;
        end
        cop_req = 1'b0;
        check("R5 cop alone ready in every slot of 8", hits, 8);
    endtask

    task automatic t_both_ram();
        int chit, phit, bad;
        align(1'b1);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h0001;
        cop_req = 1'b1; cop_we = 1'b0; cop_addr = 16'h0002;
        chit = 0; phit = 0; bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #1;
            if (cpu_rdy) chit++;
            if (cop_rdy) phit++;
            if (cpu_rdy != bus_phase_hi) bad++;
            if (cop_rdy == bus_phase_hi) bad++;
            @(posedge clk); #1;
        end
        cpu_req = 1'b0; cop_req = 1'b0;
        check("R3 cpu gets one ram slot per bus cycle", chit, 4);
        check("R4 cop keeps one ram slot per bus cycle under cpu load", phit, 4);
        check("R4 slot ownership matches phase", bad, 0);
    endtask

    task automatic t_same_addr();
        int cc, pc; logic [DW-1:0] cr, pr;
        align(1'b1);
        run_pair(1, 0, 1, 16'h0005, 16'h1111, 1, 0, 1, 16'h0005, 16'h2222, cc, cr, pc, pr);
        check("R6 cpu write in high slot", cc, 0);
        check("R6 cop write in low slot", pc, 1);
        run_pair(1, 0, 0, 16'h0005, '0, 0, 0, 0, '0, '0, cc, cr, pc, pr);
        check("R6 low-slot write wins", cr, 16'h2222);
    endtask

    task automatic t_flash_collide();
        int cc, pc; logic [DW-1:0] cr, pr;
        align(1'b1);
        run_pair(1, 0, 0, 16'h4004, '0, 1, 0, 0, 16'h4009, '0, cc, cr, pc, pr);
        check("R8 cpu served first on flash", cc, FL - 1);
        check("R8 cop held off one access", pc, 2 * FL - 1);
        check("R7 cpu flash read data", cr, 16'hB004);
        check("R7 cop flash read data", pr, 16'hB009);
        align(1'b0);
        run_pair(1, 0, 0, 16'h8003, '0, 1, 0, 1, 16'hC00A, 16'h7E7E, cc, cr, pc, pr);
        check("R7 cpu register access latency", cc, RG - 1);
        check("R8 cop register write after cpu", pc, 2 * RG - 1);
        check("R1 address 11 decodes to register block", rg_m[10], 16'h7E7E);
    endtask

    task automatic t_no_preempt();
        int cc, pc; logic [DW-1:0] cr, pr;
        align(1'b1);
        run_pair(1, 1, 0, 16'h4001, '0, 1, 0, 0, 16'h4002, '0, cc, cr, pc, pr);
        check("R9 cop access runs to completion", pc, FL - 1);
        check("R9 cpu waits for cop access", cc, 2 * FL - 1);
    endtask

    task automatic t_independent();
        int cc, pc; logic [DW-1:0] cr, pr;
        align(1'b0);
        run_pair(1, 0, 1, 16'h4010, 16'h3C3C, 1, 0, 0, 16'h8011, '0, cc, cr, pc, pr);
        check("R10 cpu flash not delayed by cop registers", cc, FL - 1);
        check("R10 cop registers not delayed by cpu flash", pc, RG - 1);
        check("R10 cop register read data", pr, 16'hC011);
        check("R1 flash write landed in flash", fl_m[16], 16'h3C3C);
        check("R1 ram untouched by flash write", ram_m[16], 16'hA010);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            ram_m[i] = 16'hA000 + 16'(i);
            fl_m[i]  = 16'hB000 + 16'(i);
            rg_m[i]  = 16'hC000 + 16'(i);
        end
        t_reset();
        t_cpu_ram_slot();
        t_cop_alone();
        t_both_ram();
        t_same_addr();
        t_flash_collide();
        t_no_preempt();
        t_independent();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule